// File: doc/BRIEF.md
# BCD Calendar Timekeeping Register File

This block keeps wall-clock time and date as packed BCD counters that step forward on a one-cycle `tick` pulse, normally one per second. Software reaches the counters, a control byte and a status byte over a simple byte bus with an address, write data, a write strobe, a read strobe and a registered read-data output.

To set the clock, software stops counting through the control byte, writes the time bytes in a burst and starts counting again. To read the clock without tearing across a carry, software requests a snapshot, which copies every live counter into a static shadow bank in one clock edge. A separate control bit then steers time reads to that shadow bank instead of the live counters. Four further control bits, plus one spare, are kept and read back but have no effect on counting.

Top module: `bcd_cal_regfile`

## Requirements
- R1: After synchronous reset the time bytes read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00, weekday 0x00; control reads 0x00, status reads 0x00 and `rd_data` is 0x00.
- R2: Byte addresses are 0x00 seconds, 0x01 minutes, 0x02 hours, 0x03 day, 0x04 month, 0x05 year, 0x06 weekday, 0x07 control, 0x08 status. Other addresses read 0x00 and ignore writes. `rd_data` is loaded on the clock edge at which `rd_en` is high and holds its value otherwise.
- R3: Control bit 0 is the run bit: while it is 1, each clock edge with `tick` high advances seconds by one; while it is 0, no counter changes except by a write.
- R4: Seconds and minutes wrap 0x59 to 0x00 and carry onward; hours wrap 0x23 to 0x00 and carry into the day and into the weekday, which counts 0x00 to 0x06 and wraps to 0x00.
- R5: Day wraps to 0x01 after the last day of the month (0x30 for months 0x04, 0x06, 0x09, 0x11; 0x29 for month 0x02 when the year value is divisible by 4, else 0x28; 0x31 otherwise) and carries into month, which wraps 0x12 to 0x01 and carries into year, which wraps 0x99 to 0x00.
- R6: A write to any time byte stores the write data at that edge, whether the counter runs or not.
- R7: When a time byte is written at the same edge as a counting tick, that tick is dropped entirely: only the written byte changes.
- R8: A control write with bit 6 set, while the stored bit 6 is 0, copies all seven live counters (their values before that edge) into the shadow bank; a control write with bit 6 set while the stored bit 6 is already 1 takes no new snapshot.
- R9: While control bit 7 is 1, reads of addresses 0x00 to 0x06 return the shadow bank; while it is 0 they return the live counters.
- R10: Control bits 1 to 5 are stored and read back unchanged and do not alter counting.
- R11: Status bit 1 reads the current run bit; all other status bits read 0. Status is read-only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counting pulse, one clock wide per second |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (4) | Byte address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |

## Verification
The bench drives the clock through second, minute, hour, day, month and year carries in one tick, through February of both a leap and a common year and through a 30-day month; a wrong month-length table would show a day of 0x29, 0x31 or 0x32 where 0x01 was due. It writes a time byte in the same cycle as a tick, where a design that still counts would show the seconds moved. It requests a snapshot twice without clearing the request bit, and once together with a tick: a level-triggered snapshot would track the live time, and a snapshot taken after the tick would be one second ahead. It also loads the stored-only control bits and checks that counting and status are unchanged.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    localparam int NUM_TIME = 7;
    localparam int IDX_W    = $clog2(NUM_TIME);

    localparam int IDX_SEC  = 0;
    localparam int IDX_MIN  = 1;
    localparam int IDX_HOUR = 2;
    localparam int IDX_DAY  = 3;
    localparam int IDX_MON  = 4;
    localparam int IDX_YEAR = 5;
    localparam int IDX_WDAY = 6;

    localparam int CTRL_OFS     = 7;
    localparam int STAT_OFS     = 8;
    localparam int STAT_RUN_BIT = 1;

    typedef logic [7:0] bcd_t;
    typedef logic [NUM_TIME-1:0][7:0] cal_time_t;

    typedef struct packed {
        logic       shadow_sel;
        logic       snap;
        logic [4:0] kept;
        logic       run;
    } cal_ctrl_t;

    typedef enum logic [1:0] {
        SEL_TIME,
        SEL_CTRL,
        SEL_STAT,
        SEL_NONE
    } cal_sel_e;

    // weekday, year, month, day, hour, minute, second
    localparam cal_time_t TIME_RESET =
        {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    function automatic bcd_t bcd_next(input bcd_t v, input bcd_t lo, input bcd_t hi);
        if (v == hi)
            return lo;
        else if (v[3:0] == 4'h9)
            return {v[7:4] + 4'h1, 4'h0};
        else
            return v + 8'h01;
    endfunction

    function automatic logic [7:0] bcd_to_bin(input bcd_t v);
        return ({4'h0, v[7:4]} * 8'd10) + {4'h0, v[3:0]};
    endfunction

    function automatic bcd_t last_day(input bcd_t mon, input bcd_t yr);
        logic [7:0] yb;
        yb = bcd_to_bin(yr);
        case (mon)
            8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/bcd_cal_counter.sv
module bcd_cal_counter
    import bcd_cal_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              run,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  bcd_t              wdata,
    output cal_time_t         live
);

    logic                time_wr;
    logic [NUM_TIME-1:0] hit;
    logic [NUM_TIME-1:0] adv;
    cal_time_t           nxt;
    logic                step, c_min, c_hour, c_day, c_mon, c_year;

    assign time_wr = wr_en && (addr < ADDR_W'(NUM_TIME));

    for (genvar i = 0; i < NUM_TIME; i++) begin : g_hit
        assign hit[i] = wr_en && (addr == ADDR_W'(i));
    end

    always_comb begin
        step   = run && tick && !time_wr;
        c_min  = step   && (live[IDX_SEC]  == 8'h59);
        c_hour = c_min  && (live[IDX_MIN]  == 8'h59);
        c_day  = c_hour && (live[IDX_HOUR] == 8'h23);
        c_mon  = c_day  && (live[IDX_DAY]  == last_day(live[IDX_MON], live[IDX_YEAR]));
        c_year = c_mon  && (live[IDX_MON]  == 8'h12);
        adv    = {c_day, c_year, c_mon, c_day, c_hour, c_min, step};

        nxt[IDX_SEC]  = bcd_next(live[IDX_SEC],  8'h00, 8'h59);
        nxt[IDX_MIN]  = bcd_next(live[IDX_MIN],  8'h00, 8'h59);
        nxt[IDX_HOUR] = bcd_next(live[IDX_HOUR], 8'h00, 8'h23);
        nxt[IDX_DAY]  = bcd_next(live[IDX_DAY],  8'h01,
                                 last_day(live[IDX_MON], live[IDX_YEAR]));
        nxt[IDX_MON]  = bcd_next(live[IDX_MON],  8'h01, 8'h12);
        nxt[IDX_YEAR] = bcd_next(live[IDX_YEAR], 8'h00, 8'h99);
        nxt[IDX_WDAY] = bcd_next(live[IDX_WDAY], 8'h00, 8'h06);
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_TIME; i++) begin
            if (rst)
                live[i] <= TIME_RESET[i];
            else if (hit[i])
                live[i] <= wdata;
            else if (adv[i])
                live[i] <= nxt[i];
        end
    end

    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_en) |=> $stable(live));

    // R4
    sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !wr_en && live[IDX_SEC] == 8'h59) |=> (live[IDX_SEC] == 8'h00));

    // R5
    month_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !wr_en && live[IDX_SEC] == 8'h59 && live[IDX_MIN] == 8'h59 &&
         live[IDX_HOUR] == 8'h23 && live[IDX_DAY] == 8'h31 && live[IDX_MON] == 8'h12)
        |=> (live[IDX_MON] == 8'h01 && live[IDX_DAY] == 8'h01));

    // R6
    sec_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(IDX_SEC)) |=> (live[IDX_SEC] == $past(wdata)));

    // R7
    tick_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && wr_en && addr == ADDR_W'(IDX_MIN)) |=> $stable(live[IDX_SEC]));

endmodule

// File: rtl/bcd_cal_ctrl.sv
module bcd_cal_ctrl
    import bcd_cal_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  bcd_t              wdata,
    input  cal_time_t         live,
    output cal_ctrl_t         ctrl,
    output cal_time_t         shadow
);

    logic      ctrl_wr;
    logic      snap_req;
    cal_ctrl_t wr_ctrl;

    always_comb begin
        wr_ctrl  = cal_ctrl_t'(wdata);
        ctrl_wr  = wr_en && (addr == ADDR_W'(CTRL_OFS));
        snap_req = ctrl_wr && wr_ctrl.snap && !ctrl.snap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            shadow <= TIME_RESET;
        end else begin
            if (ctrl_wr)
                ctrl <= wr_ctrl;
            if (snap_req)
                shadow <= live;
        end
    end

    // R8
    snap_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(CTRL_OFS) && wdata[6] && !ctrl.snap)
        |=> (shadow == $past(live)));

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && addr == ADDR_W'(CTRL_OFS))) |=> $stable(shadow));

    // R10
    ctrl_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(CTRL_OFS)) |=> (ctrl == $past(wdata)));

endmodule

// File: rtl/bcd_cal_rdport.sv
module bcd_cal_rdport
    import bcd_cal_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  cal_time_t         live,
    input  cal_time_t         shadow,
    input  cal_ctrl_t         ctrl,
    output bcd_t              rd_data
);

    cal_sel_e  sel;
    cal_time_t src;
    bcd_t      rd_next;

    always_comb begin
        if (addr < ADDR_W'(NUM_TIME))
            sel = SEL_TIME;
        else if (addr == ADDR_W'(CTRL_OFS))
            sel = SEL_CTRL;
        else if (addr == ADDR_W'(STAT_OFS))
            sel = SEL_STAT;
        else
            sel = SEL_NONE;

        src     = ctrl.shadow_sel ? shadow : live;
        rd_next = '0;
        case (sel)
            SEL_TIME: rd_next = src[addr[IDX_W-1:0]];
            SEL_CTRL: rd_next = ctrl;
            SEL_STAT: rd_next[STAT_RUN_BIT] = ctrl.run;
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_next;
    end

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R11
    stat_run_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_W'(STAT_OFS))
        |=> (rd_data[STAT_RUN_BIT] == $past(ctrl.run) && $countones(rd_data) <= 1));

endmodule

// File: rtl/bcd_cal_regfile.sv
module bcd_cal_regfile
    import bcd_cal_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rd_data
);

    cal_time_t live;
    cal_time_t shadow;
    cal_ctrl_t ctrl;

    bcd_cal_counter #(.ADDR_W(ADDR_W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .run   (ctrl.run),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .live  (live)
    );

    bcd_cal_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .live   (live),
        .ctrl   (ctrl),
        .shadow (shadow)
    );

    bcd_cal_rdport #(.ADDR_W(ADDR_W)) u_rdport (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .addr    (addr),
        .live    (live),
        .shadow  (shadow),
        .ctrl    (ctrl),
        .rd_data (rd_data)
    );

endmodule

// File: tb/bcd_cal_regfile_bench.sv
module bcd_cal_regfile_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rd_data;

    int tests = 0;
    int fails = 0;

    int         t_m[7];
    int         sh_m[7];
    int         ctrl_m;
    logic [7:0] rd_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_cal_regfile u_bcd_cal_regfile (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (rd_data)
    );

    function automatic logic [7:0] to_bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int from_bcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int month_len(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] model_read(int a);
        if (a < 7)  return to_bcd(ctrl_m[7] ? sh_m[a] : t_m[a]);
        if (a == 7) return 8'(ctrl_m);
        if (a == 8) return (ctrl_m[0]) ? 8'h02 : 8'h00;
        return 8'h00;
    endfunction

    task automatic model_advance();
        t_m[0]++;
        if (t_m[0] == 60) begin
            t_m[0] = 0; t_m[1]++;
            if (t_m[1] == 60) begin
                t_m[1] = 0; t_m[2]++;
                if (t_m[2] == 24) begin
                    t_m[2] = 0;
                    t_m[6] = (t_m[6] + 1) % 7;
                    t_m[3]++;
                    if (t_m[3] > month_len(t_m[4], t_m[5])) begin
                        t_m[3] = 1; t_m[4]++;
                        if (t_m[4] > 12) begin
                            t_m[4] = 1;
                            t_m[5] = (t_m[5] + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic model_edge(logic we, logic re, int a, logic [7:0] d, logic tk);
        if (re) rd_exp = model_read(a);
        if (we && a == 7 && d[6] && !ctrl_m[6])
            for (int i = 0; i < 7; i++) sh_m[i] = t_m[i];
        if (we && a < 7)
            t_m[a] = from_bcd(d);
        else if (ctrl_m[0] && tk)
            model_advance();
        if (we && a == 7) ctrl_m = int'(d);
    endtask

    task automatic cyc(logic we, logic re, int a, logic [7:0] d, logic tk, string tag);
        @(negedge clk);
        wr_en = we; rd_en = re; addr = 4'(a); wdata = d; tick = tk;
        @(posedge clk);
        model_edge(we, re, a, d, tk);
        #1;
        tests++;
        if (rd_data !== rd_exp) begin
            fails++;
            $display("FAIL %s: addr %0d rd_data=%02h expected %02h", tag, a, rd_data, rd_exp);
        end
    endtask

    task automatic wr(int a, logic [7:0] d, string tag);
        cyc(1'b1, 1'b0, a, d, 1'b0, tag);
    endtask

    task automatic rd(int a, string tag);
        cyc(1'b0, 1'b1, a, 8'h00, 1'b0, tag);
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 0, 8'h00, 1'b1, tag);
    endtask

    task automatic rd_all(string tag);
        for (int a = 0; a < 9; a++) rd(a, tag);
    endtask

    task automatic load_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h,
                             logic [7:0] dd, logic [7:0] mo, logic [7:0] y, string tag);
        wr(0, s, tag); wr(1, mi, tag); wr(2, h, tag);
        wr(3, dd, tag); wr(4, mo, tag); wr(5, y, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_m = '{0, 0, 0, 1, 1, 0, 0};
        sh_m = '{0, 0, 0, 1, 1, 0, 0};
        ctrl_m = 0;
        rd_exp = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset values of every register
        rd_all("R1");

        // R3 stopped counter ignores ticks
        ticks(5, "R3");
        rd(0, "R3");

        // R2 unmapped address ignores writes and reads zero
        wr(12, 8'hAA, "R2");
        rd(12, "R2");
        rd(7, "R2");
        rd_all("R2");

        // R6 load while stopped: common-year end of February
        load_time(8'h58, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, "R6");
        wr(6, 8'h06, "R6");
        rd_all("R6");

        // R3 start counting
        wr(7, 8'h01, "R3");
        ticks(1, "R3");
        rd(0, "R3");
        // R4 / R5 full carry into March, weekday 06 -> 00
        ticks(1, "R4");
        rd_all("R4");
        rd_all("R5");
        // R11 status while running
        rd(8, "R11");

        // R5 leap-year February
        wr(7, 8'h00, "R5");
        load_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, "R5");
        wr(7, 8'h01, "R5");
        ticks(1, "R5");
        rd_all("R5");
        // R6 writes while running, then leave February 29
        wr(0, 8'h59, "R6"); wr(1, 8'h59, "R6"); wr(2, 8'h23, "R6");
        rd(2, "R6");
        ticks(1, "R5");
        rd_all("R5");

        // R5 year wrap 99 -> 00
        load_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, "R5");
        ticks(1, "R5");
        rd_all("R5");

        // R5 thirty-day month
        load_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h07, "R5");
        ticks(1, "R5");
        rd(3, "R5");
        rd(4, "R5");

        // R4 digit carry 09 -> 10 inside seconds
        wr(0, 8'h08, "R4");
        ticks(2, "R4");
        rd(0, "R4");

        // R7 write with simultaneous tick drops the tick
        cyc(1'b1, 1'b0, 1, 8'h10, 1'b1, "R7");
        rd(0, "R7");
        rd(1, "R7");

        // R8 / R9 snapshot and shadow reads
        wr(7, 8'hC1, "R8");
        ticks(3, "R9");
        rd_all("R9");
        wr(7, 8'hC1, "R8");
        ticks(2, "R8");
        rd(0, "R8");
        wr(7, 8'h81, "R8");
        wr(7, 8'hC1, "R8");
        rd(0, "R8");
        // R8 snapshot in the same cycle as a tick keeps pre-tick value
        wr(7, 8'h81, "R8");
        cyc(1'b1, 1'b0, 7, 8'hC1, 1'b1, "R8");
        rd(0, "R8");
        // R9 back to live reads
        wr(7, 8'h01, "R9");
        rd(0, "R9");

        // R10 stored-only bits read back and do not change counting
        wr(7, 8'h3F, "R10");
        rd(7, "R10");
        ticks(3, "R10");
        rd(0, "R10");
        rd(8, "R11");

        // R11 / R3 stop and confirm freeze
        wr(7, 8'h00, "R11");
        rd(8, "R11");
        ticks(4, "R3");
        rd_all("R3");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule